// File: doc/BRIEF.md
# Card Host Interrupt Status Controller

This block gathers the event strobes of a card host controller into two status registers, one for normal events and one for error events, and drives a single interrupt request line toward the processor. Each status register has two masks. The status-enable mask decides whether an event is recorded at all. The signal-enable mask decides whether a recorded bit reaches the interrupt line. Software reads the status registers through a small register port and acknowledges bits by writing ones to them.

The card interrupt is not a stored event. It is a live, level-sensitive copy of the card's interrupt input. Software masks it by clearing its status-enable bit, and a write-one cannot acknowledge it. Bit 15 of the normal status register is a summary of the error register: it is high while any error status bit is set, and it can be cleared only by clearing the error bits.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A pulse on `evt_pulse[i]` whose status-enable bit `i` is set makes normal status bit `i` read one from the next cycle on. The bit mapping is: 0 command complete, 1 transfer complete, 2 block gap, 3 DMA boundary, 4 write buffer ready, 5 read buffer ready, 6 card inserted, 7 card removed.
- R3: A pulse whose status-enable bit is clear is not recorded. Clearing a status-enable bit does not erase a bit that is already recorded.
- R4: A write to a status register (normal at address 0, error at address 1) clears each recorded bit written with one. Bits written with zero keep their value.
- R5: When an enabled event arrives in the same cycle as a write-one to its own bit, the bit stays set.
- R6: Normal status bit 8 equals `card_irq_lvl` AND status-enable bit 8, in the same cycle. Writing one to bit 8 has no effect on it.
- R7: A pulse on `err_pulse[j]` whose error status-enable bit `j` is set sets error status bit `j` (bit 0 command timeout, bit 1 data timeout). Acknowledgement works as in R4.
- R8: Normal status bit 15 reads one exactly while the error status register is nonzero. Writes to bit 15 have no effect.
- R9: `irq` is registered. One cycle after any normal bit 0..8 is set together with its signal-enable bit (address 4), or any error bit is set together with its error signal-enable bit (address 5), `irq` is high; otherwise it is low.
- R10: The enable registers read back what was written: the normal status-enable at address 2 and the normal signal-enable at address 4 keep bits 8..0; the error status-enable at address 3 and the error signal-enable at address 5 keep bits 11..0. Their other bits read zero.
- R11: Addresses 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| evt_pulse | input | 8 | One-cycle normal event strobes |
| err_pulse | input | 12 | One-cycle error event strobes |
| card_irq_lvl | input | 1 | Level interrupt from the card |
| irq | output | 1 | Registered interrupt request |

## Verification
The in-design properties check four rules on every cycle. An enabled event always wins over a same-cycle acknowledge. No status bit appears without an enabled event. An acknowledge without a new event empties the bit. The interrupt line follows its masked sources one cycle later. The summary bit's release is also checked on every cycle once the error register is cleared. The card level's immunity to write-one, the register address decode, and the rule that disabling an enable does not erase recorded bits appear only in the bench's scenarios. So does the overall agreement of every readable register with an independent model under random traffic.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  typedef enum logic [2:0] {
    RA_NSTAT = 3'd0,
    RA_ESTAT = 3'd1,
    RA_NSEN  = 3'd2,
    RA_ESEN  = 3'd3,
    RA_NSIG  = 3'd4,
    RA_ESIG  = 3'd5
  } hirq_addr_e;
endpackage

// File: rtl/hirq_rst_sync.sv
module hirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_n;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/hirq_w1c_bank.sv
module hirq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_n;
  logic [W-1:0] hit;
  logic [W-1:0] clr;

  always_comb begin
    hit = set_i & en_i;
    clr = clr_wr_i ? clr_mask_i : '0;
    q_n = (q_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_n;
  end

  assign q_o = q_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & en_i)) |=> ((q_o & $past(set_i & en_i)) == $past(set_i & en_i))); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((q_o & ~$past(q_o) & ~$past(set_i & en_i)) == '0)); // R3

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((q_o & $past(clr_mask_i & ~(set_i & en_i))) == '0)); // R4
endmodule

// File: rtl/hirq_line.sv
module hirq_line #(
  parameter int NW = 9,
  parameter int EW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] nsrc_i,
  input  logic [NW-1:0] nsig_i,
  input  logic [EW-1:0] esrc_i,
  input  logic [EW-1:0] esig_i,
  output logic          irq_o
);
  logic want;
  logic irq_q;
  logic irq_n;

  always_comb begin
    want  = (|(nsrc_i & nsig_i)) | (|(esrc_i & esig_i));
    irq_n = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(nsrc_i & nsig_i)) || (|(esrc_i & esig_i))) |=> irq_o); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (((nsrc_i & nsig_i) == '0) && ((esrc_i & esig_i) == '0)) |=> !irq_o); // R9
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hirq_pkg::*;
#(
  parameter int NUM_EDGE = 8,
  parameter int ERR_W    = 12,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_EDGE-1:0] evt_pulse,
  input  logic [ERR_W-1:0]    err_pulse,
  input  logic                card_irq_lvl,
  output logic                irq
);
  localparam int CARD_BIT = NUM_EDGE;
  localparam int NEN_W    = NUM_EDGE + 1;
  localparam int SUM_BIT  = DATA_W - 1;

  logic rst_core_n;

  hirq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_core_n)
  );

  // register write decode
  logic wr_nstat, wr_estat, wr_nsen, wr_esen, wr_nsig, wr_esig;
  always_comb begin
    wr_nstat = 1'b0;
    wr_estat = 1'b0;
    wr_nsen  = 1'b0;
    wr_esen  = 1'b0;
    wr_nsig  = 1'b0;
    wr_esig  = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        RA_NSTAT: wr_nstat = 1'b1;
        RA_ESTAT: wr_estat = 1'b1;
        RA_NSEN:  wr_nsen  = 1'b1;
        RA_ESEN:  wr_esen  = 1'b1;
        RA_NSIG:  wr_nsig  = 1'b1;
        RA_ESIG:  wr_esig  = 1'b1;
        default:  ;
      endcase
    end
  end

  // enable masks
  logic [NEN_W-1:0] nsen_q, nsen_n, nsig_q, nsig_n;
  logic [ERR_W-1:0] esen_q, esen_n, esig_q, esig_n;

  always_comb begin
    nsen_n = wr_nsen ? reg_wdata[NEN_W-1:0] : nsen_q;
    nsig_n = wr_nsig ? reg_wdata[NEN_W-1:0] : nsig_q;
    esen_n = wr_esen ? reg_wdata[ERR_W-1:0] : esen_q;
    esig_n = wr_esig ? reg_wdata[ERR_W-1:0] : esig_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      nsen_q <= '0;
      nsig_q <= '0;
      esen_q <= '0;
      esig_q <= '0;
    end else begin
      if (wr_nsen) nsen_q <= nsen_n;
      if (wr_nsig) nsig_q <= nsig_n;
      if (wr_esen) esen_q <= esen_n;
      if (wr_esig) esig_q <= esig_n;
    end
  end

  // status banks
  logic [NUM_EDGE-1:0] nstat_q;
  logic [ERR_W-1:0]    estat_q;

  hirq_w1c_bank #(.W(NUM_EDGE)) u_nbank (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .set_i      (evt_pulse),
    .en_i       (nsen_q[NUM_EDGE-1:0]),
    .clr_wr_i   (wr_nstat),
    .clr_mask_i (reg_wdata[NUM_EDGE-1:0]),
    .q_o        (nstat_q)
  );

  hirq_w1c_bank #(.W(ERR_W)) u_ebank (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .set_i      (err_pulse),
    .en_i       (esen_q),
    .clr_wr_i   (wr_estat),
    .clr_mask_i (reg_wdata[ERR_W-1:0]),
    .q_o        (estat_q)
  );

  // normal status view: stored edges, live card level, error summary
  logic             card_bit;
  logic             err_sum;
  logic [DATA_W-1:0] nstat_view;

  always_comb begin
    card_bit   = card_irq_lvl & nsen_q[CARD_BIT];
    err_sum    = |estat_q;
    nstat_view = '0;
    nstat_view[NUM_EDGE-1:0] = nstat_q;
    nstat_view[CARD_BIT]     = card_bit;
    nstat_view[SUM_BIT]      = err_sum;
  end

  hirq_line #(.NW(NEN_W), .EW(ERR_W)) u_line (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .nsrc_i (nstat_view[NEN_W-1:0]),
    .nsig_i (nsig_q),
    .esrc_i (estat_q),
    .esig_i (esig_q),
    .irq_o  (irq)
  );

  // read mux
  always_comb begin
    case (reg_addr)
      RA_NSTAT: reg_rdata = nstat_view;
      RA_ESTAT: reg_rdata = DATA_W'(estat_q);
      RA_NSEN:  reg_rdata = DATA_W'(nsen_q);
      RA_ESEN:  reg_rdata = DATA_W'(esen_q);
      RA_NSIG:  reg_rdata = DATA_W'(nsig_q);
      RA_ESIG:  reg_rdata = DATA_W'(esig_q);
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:ERR_W];

  AST_SUMMARY_RELEASE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_estat && ((estat_q & ~reg_wdata[ERR_W-1:0]) == '0) && ((err_pulse & esen_q) == '0))
      |=> !nstat_view[SUM_BIT]); // R8

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(wr_nsen || wr_nsig || wr_esen || wr_esig) |=> $stable({nsen_q, nsig_q, esen_q, esig_q})); // R10
endmodule

// File: tb/host_irq_ctrl_test.sv
module host_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [7:0]  evt_pulse;
  logic [11:0] err_pulse;
  logic        card_irq_lvl;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state
  logic [7:0]  m_nq;
  logic [11:0] m_eq;
  logic [8:0]  m_nsen, m_nsig;
  logic [11:0] m_esen, m_esig;
  logic        m_irq;

  host_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .err_pulse(err_pulse), .card_irq_lvl(card_irq_lvl), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [8:0] nview9(input logic cd);
    return {cd & m_nsen[8], m_nq};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] a, input logic cd);
    case (a)
      3'd0: return {|m_eq, 6'b0, nview9(cd)};
      3'd1: return {4'b0, m_eq};
      3'd2: return {7'b0, m_nsen};
      3'd3: return {4'b0, m_esen};
      3'd4: return {7'b0, m_nsig};
      3'd5: return {4'b0, m_esig};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R7";
      3'd6, 3'd7: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic w, input logic [15:0] d,
                      input logic [7:0] ev, input logic [11:0] er, input logic cd,
                      input string tag);
    logic [7:0]  nq_n;
    logic [11:0] eq_n;
    logic        irq_n;
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d;
    evt_pulse = ev; err_pulse = er; card_irq_lvl = cd;
    #1;
    check(reg_rdata, exp_rd(a, cd), tag);
    check({15'b0, irq}, {15'b0, m_irq}, "R9");
    irq_n = (|(nview9(cd) & m_nsig)) | (|(m_eq & m_esig));
    nq_n  = (m_nq & ~((w && a == 3'd0) ? d[7:0] : 8'h00)) | (ev & m_nsen[7:0]);
    eq_n  = (m_eq & ~((w && a == 3'd1) ? d[11:0] : 12'h000)) | (er & m_esen);
    @(posedge clk);
    m_nq = nq_n; m_eq = eq_n; m_irq = irq_n;
    if (w && a == 3'd2) m_nsen = d[8:0];
    if (w && a == 3'd3) m_esen = d[11:0];
    if (w && a == 3'd4) m_nsig = d[8:0];
    if (w && a == 3'd5) m_esig = d[11:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] seed;
    seed = 16'(($urandom(32'd20240611)));
    m_nq = '0; m_eq = '0; m_nsen = '0; m_nsig = '0; m_esen = '0; m_esig = '0; m_irq = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    evt_pulse = '0; err_pulse = '0; card_irq_lvl = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state of every address
    for (int a = 0; a < 8; a++) step(3'(a), 1'b0, 16'h0, 8'h0, 12'h0, 1'b1, "R1");

    // R10: enable registers, only defined bits kept
    step(3'd4, 1'b1, 16'hFFFF, 8'h0, 12'h0, 1'b0, "R10");
    step(3'd4, 1'b0, 16'h0, 8'h0, 12'h0, 1'b0, "R10");
    step(3'd5, 1'b1, 16'hFFFF, 8'h0, 12'h0, 1'b0, "R10");
    step(3'd5, 1'b0, 16'h0, 8'h0, 12'h0, 1'b0, "R10");
    // R11: unused address write has no effect
    step(3'd6, 1'b1, 16'hFFFF, 8'h0, 12'h0, 1'b0, "R11");
    step(3'd6, 1'b0, 16'h0, 8'h0, 12'h0, 1'b0, "R11");
    // R3: event with status-enable clear is dropped
    step(3'd0, 1'b0, 16'h0, 8'h01, 12'h0, 1'b0, "R3");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R3");
    // R2: enable and record read-buffer-ready (bit 5)
    step(3'd2, 1'b1, 16'hFFFF, 8'h0, 12'h0, 1'b0, "R10");
    step(3'd2, 1'b0, 16'h0, 8'h20, 12'h0, 1'b0, "R10");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R2");
    // R5: event and acknowledge of same bit in one cycle
    step(3'd0, 1'b1, 16'h0020, 8'h20, 12'h0, 1'b0, "R5");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R5");
    // R4: write zero keeps, write one clears
    step(3'd0, 1'b1, 16'h0000, 8'h00, 12'h0, 1'b0, "R4");
    step(3'd0, 1'b1, 16'h0020, 8'h00, 12'h0, 1'b0, "R4");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R4");
    // R3: disabling enable keeps a recorded bit
    step(3'd0, 1'b0, 16'h0, 8'h80, 12'h0, 1'b0, "R3");
    step(3'd2, 1'b1, 16'h0000, 8'h00, 12'h0, 1'b0, "R3");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R3");
    step(3'd0, 1'b1, 16'h0080, 8'h00, 12'h0, 1'b0, "R4");
    // R6: live card level, immune to acknowledge, masked by enable
    step(3'd2, 1'b1, 16'h0100, 8'h00, 12'h0, 1'b0, "R10");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b1, "R6");
    step(3'd0, 1'b1, 16'h0100, 8'h00, 12'h0, 1'b1, "R6");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b1, "R6");
    step(3'd2, 1'b1, 16'h0000, 8'h00, 12'h0, 1'b1, "R6");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b1, "R6");
    // R7 / R8: data timeout, summary bit, summary release
    step(3'd3, 1'b1, 16'h0003, 8'h00, 12'h0, 1'b0, "R10");
    step(3'd1, 1'b0, 16'h0, 8'h00, 12'h002, 1'b0, "R7");
    step(3'd1, 1'b0, 16'h0, 8'h00, 12'h004, 1'b0, "R7");
    step(3'd0, 1'b1, 16'h8000, 8'h00, 12'h0, 1'b0, "R8");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R8");
    step(3'd1, 1'b1, 16'h0002, 8'h00, 12'h0, 1'b0, "R7");
    step(3'd0, 1'b0, 16'h0, 8'h00, 12'h0, 1'b0, "R8");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  a;
      logic        w;
      logic [15:0] d;
      logic [7:0]  ev;
      logic [11:0] er;
      logic        cd;
      a  = 3'($urandom % 8);
      w  = ($urandom % 4) == 0;
      d  = 16'($urandom);
      if (a <= 3'd1) d = d & 16'($urandom);
      ev = (($urandom % 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      er = (($urandom % 6) == 0) ? 12'($urandom) & 12'($urandom) : 12'h000;
      cd = (($urandom % 8) == 0) ? ~card_irq_lvl : card_irq_lvl;
      step(a, w, d, ev, er, cd, addr_tag(a));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule